// File: doc/BRIEF.md
# Range-Matching TLB with Pinned Block Entries

This block is a fully associative address translation buffer. Each entry holds a virtual range given by an inclusive begin and end address, a physical base and a set of attribute fields. A translation is found by comparing the lookup address against every range at once. The physical address is the entry's base plus the offset of the address from the range begin. Lookup is purely combinational.

The lowest slots of the table are reserved as pinned block entries. They can span many pages and are written only by slot number. Ordinary page operations, including eviction, purge by address and purge of all pages, cannot remove them. The remaining slots hold single pages. These are loaded in two steps: an address insert claims a slot, and a protection insert then fills the attributes and marks the entry valid.

All commands arrive on one command port. Each command takes effect at the clock edge on which it is presented. Error status comes back as one-cycle pulses after that edge.

Top module: `rtlb_top`

## Requirements
- R1: Lookup picks the lowest-index entry whose range satisfies begin <= lk_addr <= end, whether or not that entry is valid. lk_hit is 1 only when that entry is valid. On a hit, lk_pa = base + (lk_addr - begin) and lk_attr shows the entry's attributes. On a miss, lk_pa and lk_attr are both zero.
- R2: Block slots 0..NUM_BLK-1 are unaffected by purge-by-address (op 3), by purge-all (op 4) and by allocation. Only a block insert or a block purge changes them.
- R3: After reset every entry is invalid and matches no address, including 0 and 0xFFFFFFFF. No lookup hits, both status outputs are 0, and the replacement pointer stands at NUM_BLK.
- R4: The replacement pointer works as follows. If it is below NUM_BLK or at or above NUM_ENT, slot NUM_BLK is chosen and the pointer becomes NUM_BLK+1. Otherwise the slot it names is chosen and it increments. It advances only when an address insert finds no covering page slot.
- R5: Address insert (op 1) has four effects. It invalidates every valid page slot whose range covers cmd_addr. It reuses the first covering page slot, or allocates one if there is none. It sets begin to cmd_addr with the low PAGE_BITS bits cleared, and end to begin + page size - 1. It sets base to cmd_data[24:5] shifted left by PAGE_BITS and clears the attributes. The entry stays invalid, so lookups in that page miss.
- R6: Protection insert (op 2) takes the entry that lookup would pick for cmd_addr (see R1), searching block and page slots alike. It loads cmd_data[29:1] into the attributes and sets the entry valid. If no range covers cmd_addr, nothing changes and cmd_err pulses. In the lk_attr layout, bits [17:0] are the access id, bit 18 is U, [20:19] is PL2, [22:21] is PL1, [25:23] is the type, bit 26 is B, bit 27 is D and bit 28 is T.
- R7: Purge-all (op 4) invalidates every page slot and returns the replacement pointer to NUM_BLK.
- R8: Purge-by-address (op 3) invalidates the entry lookup would pick for cmd_addr, but only when that entry is valid and is a page slot.
- R9: Block insert (op 5) applies when cmd_slot < NUM_BLK. It sets the slot to begin = cmd_vpn << PAGE_BITS, end = begin + cmd_len x page size - 1 (modulo 2^32) and base = cmd_ppn << PAGE_BITS. It loads attributes from cmd_data[29:1], then forces T = 0 and D = 1, and marks the slot valid. If cmd_slot >= NUM_BLK, nothing changes and cmd_badarg pulses.
- R10: Block purge (op 6) invalidates slot cmd_slot when cmd_slot < NUM_BLK, and otherwise pulses cmd_badarg with no change. Block purge-all (op 7) invalidates every block slot. Op 0 does nothing.
- R11: A command takes effect at the rising edge where cmd_valid is 1. cmd_err and cmd_badarg are registered, are high only in the cycle after that edge, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 none, 1 address insert, 2 protection insert, 3 purge by address, 4 purge all pages, 5 block insert, 6 block purge, 7 block purge all) |
| cmd_addr | input | 32 | Virtual address for page commands |
| cmd_data | input | 32 | Physical page operand or attribute word |
| cmd_slot | input | SLOT_W (8) | Block slot number |
| cmd_vpn | input | PN_W (20) | Block virtual page number |
| cmd_ppn | input | PN_W (20) | Block physical page number |
| cmd_len | input | PN_W (20) | Block length in pages |
| cmd_err | output | 1 | Pulse: protection insert found no entry |
| cmd_badarg | output | 1 | Pulse: block slot out of range |
| lk_addr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Valid translation found |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 29 | Attributes of the hit entry |

## Verification
The bench goes after the following corner cases:
- **Overlapping ranges.** When a block range and a page range overlap, a design that searched from the top slot down would return the wrong base.
- **Half-inserted entries.** An invalid entry still shadows valid entries behind it in the search. A design that skipped invalid entries during lookup would report a hit where a miss is expected.
- **Pointer wrap and purge-all.** The table is filled past its end. A pointer that wrapped to slot 0, or that was not restored by purge-all, would evict a block entry or the wrong page; this shows up as a wrong lookup result afterwards.
- **Protected block slots.** Purges are aimed at block addresses, block operands are given with T set and D clear, and slot numbers of NUM_BLK and above are tried. A design that let a page purge through would lose a pinned translation. One that loaded the raw attributes would show the wrong D and T, and one that did not check the slot range would corrupt a page slot or miss the status pulse.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;

  localparam int VA_W   = 32;
  localparam int PA_W   = 32;
  localparam int ATTR_W = 29;
  localparam int ATTR_D = 27;
  localparam int ATTR_T = 28;

  typedef struct packed {
    logic              vld;
    logic [VA_W-1:0]   vb;
    logic [VA_W-1:0]   ve;
    logic [PA_W-1:0]   pa;
    logic [ATTR_W-1:0] attr;
  } tlb_ent_t;

  typedef enum logic [2:0] {
    OP_NOP           = 3'd0,
    OP_INS_ADDR      = 3'd1,
    OP_INS_PROT      = 3'd2,
    OP_PURGE_ADDR    = 3'd3,
    OP_PURGE_ALL     = 3'd4,
    OP_BLK_INS       = 3'd5,
    OP_BLK_PURGE     = 3'd6,
    OP_BLK_PURGE_ALL = 3'd7
  } tlb_op_e;

  // An empty entry: begin all ones, end zero, so no address can match it.
  function automatic tlb_ent_t f_empty();
    tlb_ent_t e;
    e.vld  = 1'b0;
    e.vb   = '1;
    e.ve   = '0;
    e.pa   = '0;
    e.attr = '0;
    return e;
  endfunction

  function automatic logic f_covers(tlb_ent_t e, logic [VA_W-1:0] a);
    return (e.vb <= a) && (a <= e.ve);
  endfunction

  function automatic logic [PA_W-1:0] f_xlate(tlb_ent_t e, logic [VA_W-1:0] a);
    return e.pa + PA_W'(a - e.vb);
  endfunction

  function automatic logic [VA_W-1:0] f_page_base(logic [VA_W-1:0] a, int pb);
    logic [VA_W-1:0] m;
    m = ~((VA_W'(1) << pb) - VA_W'(1));
    return a & m;
  endfunction

  function automatic logic [VA_W-1:0] f_range_end(logic [VA_W-1:0] b,
                                                  logic [VA_W-1:0] npages, int pb);
    return b + (npages << pb) - VA_W'(1);
  endfunction

  function automatic logic [ATTR_W-1:0] f_attr_of(logic [31:0] d);
    return d[ATTR_W:1];
  endfunction

  function automatic logic [ATTR_W-1:0] f_block_attr(logic [31:0] d);
    logic [ATTR_W-1:0] a;
    a = d[ATTR_W:1];
    a[ATTR_T] = 1'b0;
    a[ATTR_D] = 1'b1;
    return a;
  endfunction

endpackage

// File: rtl/rtlb_match.sv
module rtlb_match
  import rtlb_pkg::*;
#(
  parameter int NUM = 16,
  localparam int IW = $clog2(NUM)
) (
  input  tlb_ent_t [NUM-1:0] ents,
  input  logic [VA_W-1:0]    addr,
  output logic               found,
  output logic [IW-1:0]      idx
);

  logic [NUM-1:0] hit_vec;

  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    assign hit_vec[g] = f_covers(ents[g], addr);
  end

  // Lowest index wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/rtlb_alloc.sv
module rtlb_alloc #(
  parameter int NB = 4,
  parameter int NE = 16,
  localparam int IW = $clog2(NE),
  localparam int PW = $clog2(NE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          restart,
  output logic [IW-1:0] slot,
  output logic [PW-1:0] ptr
);

  localparam logic [PW-1:0] P_NB = PW'(NB);
  localparam logic [PW-1:0] P_NE = PW'(NE);

  logic [PW-1:0] ptr_q;
  logic          outside;

  assign outside = (ptr_q < P_NB) || (ptr_q >= P_NE);
  assign slot    = outside ? IW'(NB) : ptr_q[IW-1:0];
  assign ptr     = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      ptr_q <= P_NB;
    end else if (take) begin
      ptr_q <= outside ? P_NB + PW'(1) : ptr_q + PW'(1);
    end
  end

endmodule

// File: rtl/rtlb_top.sv
module rtlb_top
  import rtlb_pkg::*;
#(
  parameter int NUM_BLK   = 4,
  parameter int NUM_ENT   = 16,
  parameter int PAGE_BITS = 12,
  parameter int SLOT_W    = 8,
  localparam int PN_W     = VA_W - PAGE_BITS,
  localparam int IW       = $clog2(NUM_ENT),
  localparam int PW       = $clog2(NUM_ENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [VA_W-1:0]   cmd_addr,
  input  logic [31:0]       cmd_data,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic [PN_W-1:0]   cmd_vpn,
  input  logic [PN_W-1:0]   cmd_ppn,
  input  logic [PN_W-1:0]   cmd_len,
  output logic              cmd_err,
  output logic              cmd_badarg,
  input  logic [VA_W-1:0]   lk_addr,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_pa,
  output logic [ATTR_W-1:0] lk_attr
);

  localparam logic [IW-1:0]     I_NB = IW'(NUM_BLK);
  localparam logic [SLOT_W-1:0] S_NB = SLOT_W'(NUM_BLK);

  tlb_ent_t [NUM_ENT-1:0] ents_q, ents_d;
  tlb_op_e op;
  logic    err_d, bad_d;

  assign op = tlb_op_e'(cmd_op);

  logic unused_data;
  assign unused_data = ^{cmd_data[31:30], cmd_data[0]};

  // ---------------- lookup port ----------------
  logic          lk_found;
  logic [IW-1:0] lk_idx;
  tlb_ent_t      lk_ent;

  rtlb_match #(.NUM(NUM_ENT)) u_lk_match (
    .ents(ents_q), .addr(lk_addr), .found(lk_found), .idx(lk_idx)
  );

  assign lk_ent  = ents_q[lk_idx];
  assign lk_hit  = lk_found && lk_ent.vld;
  assign lk_pa   = lk_hit ? f_xlate(lk_ent, lk_addr) : '0;
  assign lk_attr = lk_hit ? lk_ent.attr : '0;

  // ---------------- command address search ----------------
  logic          cm_found;
  logic [IW-1:0] cm_idx;

  rtlb_match #(.NUM(NUM_ENT)) u_cmd_match (
    .ents(ents_q), .addr(cmd_addr), .found(cm_found), .idx(cm_idx)
  );

  // Page slots covering the command address (address insert only).
  logic [NUM_ENT-1:0] ins_cover;
  logic               ins_found;
  logic [IW-1:0]      ins_first;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cover
    if (g < NUM_BLK) begin : g_blk
      assign ins_cover[g] = 1'b0;
    end else begin : g_page
      assign ins_cover[g] = f_covers(ents_q[g], cmd_addr);
    end
  end

  always_comb begin
    ins_found = 1'b0;
    ins_first = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (ins_cover[i]) begin
        ins_found = 1'b1;
        ins_first = IW'(i);
      end
    end
  end

  // ---------------- replacement pointer ----------------
  logic          alloc_take, alloc_restart;
  logic [IW-1:0] alloc_slot;
  logic [PW-1:0] alloc_ptr;
  logic [IW-1:0] ins_slot;

  assign alloc_take    = cmd_valid && (op == OP_INS_ADDR) && !ins_found;
  assign alloc_restart = cmd_valid && (op == OP_PURGE_ALL);
  assign ins_slot      = ins_found ? ins_first : alloc_slot;

  rtlb_alloc #(.NB(NUM_BLK), .NE(NUM_ENT)) u_alloc (
    .clk(clk), .rst_n(rst_n), .take(alloc_take), .restart(alloc_restart),
    .slot(alloc_slot), .ptr(alloc_ptr)
  );

  // ---------------- named events for the checker ----------------
  logic                       ev_prot_miss;
  logic                       slot_ok;
  logic [NUM_BLK*$bits(tlb_ent_t)-1:0] blk_view;

  assign ev_prot_miss = !cm_found;
  assign slot_ok      = cmd_slot < S_NB;
  assign blk_view     = ents_q[NUM_BLK-1:0];

  // ---------------- next-state ----------------
  always_comb begin
    tlb_ent_t ne;
    ents_d = ents_q;
    err_d  = 1'b0;
    bad_d  = 1'b0;
    ne     = f_empty();
    if (cmd_valid) begin
      unique case (op)
        OP_INS_ADDR: begin
          for (int i = NUM_BLK; i < NUM_ENT; i++) begin
            if (ins_cover[i] && ents_q[i].vld) ents_d[i] = f_empty();
          end
          ne.vld  = 1'b0;
          ne.vb   = f_page_base(cmd_addr, PAGE_BITS);
          ne.ve   = f_range_end(ne.vb, VA_W'(1), PAGE_BITS);
          ne.pa   = PA_W'(cmd_data[24:5]) << PAGE_BITS;
          ne.attr = '0;
          ents_d[ins_slot] = ne;
        end
        OP_INS_PROT: begin
          if (cm_found) begin
            ents_d[cm_idx].attr = f_attr_of(cmd_data);
            ents_d[cm_idx].vld  = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
        OP_PURGE_ADDR: begin
          if (cm_found && ents_q[cm_idx].vld && (cm_idx >= I_NB))
            ents_d[cm_idx] = f_empty();
        end
        OP_PURGE_ALL: begin
          for (int i = NUM_BLK; i < NUM_ENT; i++) ents_d[i] = f_empty();
        end
        OP_BLK_INS: begin
          if (slot_ok) begin
            ne.vld  = 1'b1;
            ne.vb   = VA_W'(cmd_vpn) << PAGE_BITS;
            ne.ve   = f_range_end(ne.vb, VA_W'(cmd_len), PAGE_BITS);
            ne.pa   = PA_W'(cmd_ppn) << PAGE_BITS;
            ne.attr = f_block_attr(cmd_data);
            ents_d[cmd_slot[IW-1:0]] = ne;
          end else begin
            bad_d = 1'b1;
          end
        end
        OP_BLK_PURGE: begin
          if (slot_ok) ents_d[cmd_slot[IW-1:0]] = f_empty();
          else         bad_d = 1'b1;
        end
        OP_BLK_PURGE_ALL: begin
          for (int i = 0; i < NUM_BLK; i++) ents_d[i] = f_empty();
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) ents_q[i] <= f_empty();
      cmd_err    <= 1'b0;
      cmd_badarg <= 1'b0;
    end else begin
      ents_q     <= ents_d;
      cmd_err    <= err_d;
      cmd_badarg <= bad_d;
    end
  end

endmodule

// File: rtl/rtlb_checker.sv
module rtlb_checker #(
  parameter int NB     = 4,
  parameter int NE     = 16,
  parameter int SLOT_W = 8,
  parameter int BV_W   = 4,
  parameter int PW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [SLOT_W-1:0] cmd_slot,
  input logic              cmd_err,
  input logic              cmd_badarg,
  input logic              ev_prot_miss,
  input logic [PW-1:0]     alloc_ptr,
  input logic [BV_W-1:0]   blk_view,
  input logic              lk_hit,
  input logic [31:0]       lk_pa,
  input logic [28:0]       lk_attr
);

  logic slot_cmd_bad;
  assign slot_cmd_bad = cmd_valid && (cmd_op == 3'd5 || cmd_op == 3'd6) &&
                        (cmd_slot >= SLOT_W'(NB));

  AST_PTR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ptr >= PW'(NB)) && (alloc_ptr <= PW'(NE))); // R4

  AST_PURGE_ALL_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd4 |=> alloc_ptr == PW'(NB)); // R7

  AST_BLOCK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4 || cmd_op == 3'd1) |=> $stable(blk_view)); // R2

  AST_PROT_MISS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd2 && ev_prot_miss |=> cmd_err); // R6

  AST_BAD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cmd_bad |=> cmd_badarg); // R9

  AST_NO_SPURIOUS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_cmd_bad |=> !cmd_badarg); // R10

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_err, cmd_badarg})); // R11

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == 32'd0) && (lk_attr == 29'd0)); // R1

endmodule

bind rtlb_top rtlb_checker #(
  .NB(NUM_BLK), .NE(NUM_ENT), .SLOT_W(SLOT_W),
  .BV_W(NUM_BLK * $bits(rtlb_pkg::tlb_ent_t)), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_slot(cmd_slot), .cmd_err(cmd_err), .cmd_badarg(cmd_badarg),
  .ev_prot_miss(ev_prot_miss), .alloc_ptr(alloc_ptr), .blk_view(blk_view),
  .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr)
);

// File: tb/test_rtlb_top.sv
`timescale 1ns/1ps
module test_rtlb_top;

  localparam int NB = 4;
  localparam int NE = 16;
  localparam int PB = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_addr = '0, cmd_data = '0;
  logic [7:0]  cmd_slot = '0;
  logic [19:0] cmd_vpn = '0, cmd_ppn = '0, cmd_len = '0;
  logic        cmd_err, cmd_badarg;
  logic [31:0] lk_addr = '0;
  logic        lk_hit;
  logic [31:0] lk_pa;
  logic [28:0] lk_attr;

  always #2 clk = ~clk;

  rtlb_top i_rtlb_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_slot(cmd_slot),
    .cmd_vpn(cmd_vpn), .cmd_ppn(cmd_ppn), .cmd_len(cmd_len),
    .cmd_err(cmd_err), .cmd_badarg(cmd_badarg), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr)
  );

  int n_run = 0, n_fail = 0;

  // ---------------- reference model ----------------
  logic [31:0] m_vb [NE];
  logic [31:0] m_ve [NE];
  logic [31:0] m_pa [NE];
  logic [28:0] m_at [NE];
  bit          m_v  [NE];
  int          m_ptr;

  task automatic m_clear(int i);
    m_vb[i] = 32'hFFFF_FFFF; m_ve[i] = 0; m_pa[i] = 0; m_at[i] = 0; m_v[i] = 0;
  endtask

  function automatic int m_find(logic [31:0] a);
    for (int i = 0; i < NE; i++) if (m_vb[i] <= a && a <= m_ve[i]) return i;
    return -1;
  endfunction

  task automatic m_apply(int op, logic [31:0] a, logic [31:0] d, int slot,
                         logic [19:0] vpn, logic [19:0] ppn, logic [19:0] len,
                         output bit e_err, output bit e_bad);
    int f, s;
    e_err = 0; e_bad = 0;
    case (op)
      1: begin
        f = -1;
        for (int i = NB; i < NE; i++) begin
          if (m_vb[i] <= a && a <= m_ve[i]) begin
            if (m_v[i]) m_clear(i);
            if (f < 0) f = i;
          end
        end
        if (f < 0) begin
          if (m_ptr < NB || m_ptr >= NE) begin s = NB; m_ptr = NB + 1; end
          else begin s = m_ptr; m_ptr++; end
        end else s = f;
        m_vb[s] = {a[31:12], 12'h000};
        m_ve[s] = {a[31:12], 12'hFFF};
        m_pa[s] = {d[24:5], 12'h000};
        m_at[s] = 0; m_v[s] = 0;
      end
      2: begin
        f = m_find(a);
        if (f < 0) e_err = 1;
        else begin m_at[f] = d[29:1]; m_v[f] = 1; end
      end
      3: begin
        f = m_find(a);
        if (f >= NB && m_v[f]) m_clear(f);
      end
      4: begin
        for (int i = NB; i < NE; i++) m_clear(i);
        m_ptr = NB;
      end
      5: begin
        if (slot >= NB) e_bad = 1;
        else begin
          m_vb[slot] = {vpn, 12'h000};
          m_ve[slot] = {vpn, 12'h000} + {len, 12'h000} - 32'd1;
          m_pa[slot] = {ppn, 12'h000};
          m_at[slot] = d[29:1];
          m_at[slot][28] = 1'b0;
          m_at[slot][27] = 1'b1;
          m_v[slot] = 1;
        end
      end
      6: begin
        if (slot >= NB) e_bad = 1; else m_clear(slot);
      end
      7: for (int i = 0; i < NB; i++) m_clear(i);
      default: ;
    endcase
  endtask

  // ---------------- checking helpers ----------------
  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(logic [31:0] a, string req);
    int f;
    bit eh;
    logic [31:0] ep;
    logic [28:0] ea;
    f = m_find(a);
    eh = (f >= 0) && m_v[f];
    ep = eh ? m_pa[f] + (a - m_vb[f]) : 32'd0;
    ea = eh ? m_at[f] : 29'd0;
    @(negedge clk);
    lk_addr = a;
    #1;
    chk({lk_hit, lk_pa, lk_attr} == {eh, ep, ea}, req,
        64'({lk_hit, lk_pa, lk_attr}), 64'({eh, ep, ea}));
  endtask

  task automatic cmd(int op, logic [31:0] a, logic [31:0] d, int slot,
                     logic [19:0] vpn, logic [19:0] ppn, logic [19:0] len, string req);
    bit e_err, e_bad;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = a; cmd_data = d;
    cmd_slot = 8'(slot); cmd_vpn = vpn; cmd_ppn = ppn; cmd_len = len;
    @(posedge clk);
    #1;
    cmd_valid = 0;
    m_apply(op, a, d, slot, vpn, ppn, len, e_err, e_bad);
    chk({cmd_err, cmd_badarg} == {e_err, e_bad}, req,
        64'({cmd_err, cmd_badarg}), 64'({e_err, e_bad}));
  endtask

  function automatic logic [31:0] rnd_addr();
    return (32'($urandom_range(0, 63)) << PB) | ($urandom & 32'hFFF);
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] pa_word;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NE; i++) m_clear(i);
    m_ptr = NB;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R3: reset state
    look(32'h0000_0000, "R3 reset addr 0");
    look(32'hFFFF_FFFF, "R3 reset addr max");
    look(32'h0001_2345, "R3 reset mid");
    chk({cmd_err, cmd_badarg} == 2'b00, "R3 status idle", 64'({cmd_err, cmd_badarg}), 0);

    // R5 then R6: two-step page insert
    pa_word = {7'd0, 20'hABCDE, 5'd0};
    cmd(1, 32'h0000_5123, pa_word, 0, 0, 0, 0, "R5 address insert");
    look(32'h0000_5123, "R5 entry stays invalid");
    cmd(2, 32'h0000_5FFF, 32'h3FFF_FFFE, 0, 0, 0, 0, "R6 protection insert");
    look(32'h0000_5123, "R6 R1 hit after protection");
    look(32'h0000_6000, "R1 end of page miss");
    cmd(2, 32'h0090_0000, 32'h1234_5678, 0, 0, 0, 0, "R6 protection insert miss");
    // R11 pulse is one cycle
    @(posedge clk); #1;
    chk(cmd_err == 1'b0, "R11 err pulse ends", 64'(cmd_err), 0);

    // R9: block insert forces T=0 D=1
    cmd(5, 0, 32'h2000_0000 | 32'h0000_0246, 1, 20'h40, 20'h200, 20'd3, "R9 block insert");
    look(32'h0004_2ABC, "R9 block lookup");
    look(32'h0004_3000, "R9 block end");
    cmd(5, 0, 32'h1, 4, 20'h10, 20'h10, 20'd1, "R9 slot equal N");
    @(posedge clk); #1;
    chk(cmd_badarg == 1'b0, "R11 badarg pulse ends", 64'(cmd_badarg), 0);
    cmd(5, 0, 32'h1, 200, 20'h10, 20'h10, 20'd1, "R9 slot large");
    look(32'h0001_0000, "R9 bad slot no effect");

    // R1: overlap priority, lowest index wins
    cmd(5, 0, 32'h0, 2, 20'h60, 20'h700, 20'd4, "R1 setup slot2");
    cmd(5, 0, 32'h0, 0, 20'h62, 20'h900, 20'd4, "R1 setup slot0");
    look(32'h0006_2010, "R1 overlap lowest index");
    look(32'h0006_1010, "R1 only slot2");

    // R2 and R8: purges by address
    cmd(3, 32'h0004_2000, 0, 0, 0, 0, 0, "R2 purge on block addr");
    look(32'h0004_2000, "R2 block survives purge-addr");
    cmd(3, 32'h0000_5000, 0, 0, 0, 0, 0, "R8 purge page");
    look(32'h0000_5000, "R8 page purged");

    // R7 and R4: fill page slots past end, pointer wrap
    cmd(4, 0, 0, 0, 0, 0, 0, "R7 purge all");
    look(32'h0004_2000, "R2 block survives purge-all");
    for (int k = 0; k < 14; k++) begin
      cmd(1, 32'h0010_0000 + 32'(k << PB), 32'(k << 5), 0, 0, 0, 0, "R4 fill insert");
      cmd(2, 32'h0010_0000 + 32'(k << PB), 32'h0000_0002, 0, 0, 0, 0, "R4 fill protect");
    end
    look(32'h0010_0000, "R4 oldest page evicted");
    look(32'h0010_1000, "R4 second evicted");
    look(32'h0010_2000, "R4 third kept");
    look(32'h0010_D000, "R4 newest kept");
    look(32'h0006_2000, "R4 block not evicted");

    // R5: reinsert over covering page
    cmd(1, 32'h0010_3456, {7'd0, 20'h55555, 5'd0}, 0, 0, 0, 0, "R5 reuse covering");
    look(32'h0010_3000, "R5 reused entry invalid");
    cmd(2, 32'h0010_3000, 32'h0000_0010, 0, 0, 0, 0, "R5 reprotect");
    look(32'h0010_3456, "R5 new pa");

    // R10: block purges
    cmd(6, 0, 0, 0, 0, 0, 0, "R10 purge slot0");
    look(32'h0006_2010, "R10 slot2 exposed");
    cmd(6, 0, 0, 7, 0, 0, 0, "R10 bad slot purge");
    cmd(7, 0, 0, 0, 0, 0, 0, "R10 purge all blocks");
    look(32'h0004_2000, "R10 blocks gone");
    cmd(0, 32'h0010_2000, 0, 0, 0, 0, 0, "R10 nop");
    look(32'h0010_2000, "R10 nop no effect");

    // random mix
    for (int n = 0; n < 500; n++) begin
      int op, r;
      r = $urandom_range(0, 99);
      if      (r < 30) op = 1;
      else if (r < 60) op = 2;
      else if (r < 70) op = 3;
      else if (r < 73) op = 4;
      else if (r < 85) op = 5;
      else if (r < 92) op = 6;
      else if (r < 94) op = 7;
      else             op = 0;
      cmd(op, rnd_addr(), $urandom, $urandom_range(0, 5),
          20'($urandom_range(0, 63)), 20'($urandom), 20'($urandom_range(0, 4)),
          "R11 random command status");
      for (int j = 0; j < 3; j++) look(rnd_addr(), "R1 random lookup");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule